// File: doc/BRIEF.md
# Sixteen-bit ALU with selective flag updates

This is a purely combinational arithmetic and logic unit for a small accumulator-style processor. It takes two data operands, the current carry flag and a four-bit operation code. It returns a result, a strobe that says whether the result should be written back, and new zero, carry, negative and overflow values. Each of the four flag values comes with its own update enable, so the surrounding flag register changes only the flags that the operation owns.

Arithmetic operations are addition, addition with carry-in, subtraction, subtraction with borrow-in, compare, negate, increment and decrement. Bitwise operations are complement, AND, OR, XOR and test. Three further codes act on the carry flag alone: they set it, clear it or toggle it. Compare and test produce flags but no write-back. The data width is a parameter (default 16). A second parameter selects a behavioural adder or an explicit ripple-carry chain.

Top module: `flex_alu`

## Requirements
- R1: Operation encoding on `op_i`: 0 ADD, 1 ADC, 2 SUB, 3 SBB, 4 CMP, 5 NEG, 6 INC, 7 DEC, 8 NOT, 9 AND, 10 OR, 11 XOR, 12 TST, 13 SETC, 14 CLRC, 15 TGLC.
- R2: ADD gives a+b and ADC gives a+b+c_i, truncated to WIDTH bits. The carry value is the carry out of the top bit.
- R3: SUB and CMP compute a-b, and SBB computes a-b-c_i. The carry value is 1 exactly when a borrow occurs, i.e. when unsigned a < b + borrow-in.
- R4: The overflow value is 1 exactly when the true signed result of an arithmetic operation does not fit in WIDTH bits.
- R5: The zero value is 1 exactly when the result is all zeros. The negative value equals the result's top bit.
- R6: Every arithmetic operation (ADD, ADC, SUB, SBB, CMP, NEG, INC, DEC) raises all four flag enables.
- R7: The bitwise operations (NOT, AND, OR, XOR, TST) raise only the zero and negative enables. The carry and overflow enables stay 0.
- R8: CMP and TST drive `res_we_o` low. Every other arithmetic or bitwise operation drives it high. CMP returns the SUB difference, and TST returns the AND value.
- R9: NEG gives 0-a, INC gives a+1 and DEC gives a-1. All three ignore `c_i` and `b_i`.
- R10: SETC, CLRC and TGLC raise only the carry enable, with value 1, 0 and the inverse of `c_i` respectively. They drive `res_we_o` low and the result to zero.
- R11: A flag value whose enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1) |
| a_i | input | WIDTH | First operand / minuend |
| b_i | input | WIDTH | Second operand / subtrahend |
| c_i | input | 1 | Current carry flag |
| res_o | output | WIDTH | Operation result |
| res_we_o | output | 1 | Result write-back enable |
| z_o | output | 1 | Zero value |
| z_we_o | output | 1 | Zero update enable |
| c_o | output | 1 | Carry value |
| c_we_o | output | 1 | Carry update enable |
| n_o | output | 1 | Negative value |
| n_we_o | output | 1 | Negative update enable |
| v_o | output | 1 | Overflow value |
| v_we_o | output | 1 | Overflow update enable |

## Verification
The checks are immediate assertions. They assume the inputs have settled to known 0/1 values whenever the outputs are compared, and that `op_i` carries one of the sixteen codes of R1. Every code is defined, so no operation value lies outside the legal set.

The stimulus holds this condition by changing inputs only on the falling clock edge and reading outputs one rising edge later. It drives each code explicitly, including the boundary operands 0x0000, 0x7FFF, 0x8000 and 0xFFFF with `c_i` both 0 and 1.

// File: rtl/flex_alu_pkg.sv
package flex_alu_pkg;
   localparam int OPW = 4;

   typedef enum logic [OPW-1:0] {
      OP_ADD  = 4'd0,
      OP_ADC  = 4'd1,
      OP_SUB  = 4'd2,
      OP_SBB  = 4'd3,
      OP_CMP  = 4'd4,
      OP_NEG  = 4'd5,
      OP_INC  = 4'd6,
      OP_DEC  = 4'd7,
      OP_NOT  = 4'd8,
      OP_AND  = 4'd9,
      OP_OR   = 4'd10,
      OP_XOR  = 4'd11,
      OP_TST  = 4'd12,
      OP_SETC = 4'd13,
      OP_CLRC = 4'd14,
      OP_TGLC = 4'd15
   } alu_op_e;
endpackage

// File: rtl/flex_alu_adder.sv
module flex_alu_adder #(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             ci_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             co_o
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = ci_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]  = x_i[i] ^ y_i[i] ^ cy[i];
            assign cy[i+1]   = (x_i[i] & y_i[i]) | (cy[i] & (x_i[i] ^ y_i[i]));
         end
         assign co_o = cy[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] full;
         assign full  = {1'b0, x_i} + {1'b0, y_i} + (WIDTH+1)'(ci_i);
         assign sum_o = full[WIDTH-1:0];
         assign co_o  = full[WIDTH];
      end
   endgenerate
endmodule

// File: rtl/flex_alu_logic.sv
module flex_alu_logic
   import flex_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o
);
   always_comb begin
      unique case (op_i)
         OP_NOT:         res_o = ~a_i;
         OP_AND, OP_TST: res_o = a_i & b_i;
         OP_OR:          res_o = a_i | b_i;
         OP_XOR:         res_o = a_i ^ b_i;
         default:        res_o = '0;
      endcase
   end
endmodule

// File: rtl/flex_alu_flags.sv
module flex_alu_flags
   import flex_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] res_i,
   input  logic             arith_i,
   input  logic             bitw_i,
   input  logic             cop_i,
   input  logic             c_i,
   input  logic             ar_c_i,
   input  logic             ar_v_i,
   output logic             z_o,
   output logic             z_we_o,
   output logic             c_o,
   output logic             c_we_o,
   output logic             n_o,
   output logic             n_we_o,
   output logic             v_o,
   output logic             v_we_o
);
   localparam int MSB = WIDTH - 1;

   logic zn_en;
   logic cop_val;

   assign zn_en  = arith_i | bitw_i;
   assign z_we_o = zn_en;
   assign n_we_o = zn_en;
   assign z_o    = zn_en & (res_i == '0);
   assign n_o    = zn_en & res_i[MSB];

   always_comb begin
      unique case (op_i)
         OP_SETC: cop_val = 1'b1;
         OP_CLRC: cop_val = 1'b0;
         OP_TGLC: cop_val = ~c_i;
         default: cop_val = 1'b0;
      endcase
   end

   assign c_we_o = arith_i | cop_i;
   assign c_o    = arith_i ? ar_c_i : (cop_i & cop_val);
   assign v_we_o = arith_i;
   assign v_o    = arith_i & ar_v_i;
endmodule

// File: rtl/flex_alu.sv
module flex_alu
   import flex_alu_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             c_i,
   output logic [WIDTH-1:0] res_o,
   output logic             res_we_o,
   output logic             z_o,
   output logic             z_we_o,
   output logic             c_o,
   output logic             c_we_o,
   output logic             n_o,
   output logic             n_we_o,
   output logic             v_o,
   output logic             v_we_o
);
   localparam int              MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("flex_alu: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e          op;
   logic             arith, bitw, cop, sub, use_c, wr;
   logic [WIDTH-1:0] a_sel, b_sel, add_y, sum, lg_res;
   logic             cin_eff, add_ci, cout, ar_c, ar_v;

   assign op = alu_op_e'(op_i);

   // R1 decode
   always_comb begin
      arith = 1'b0; bitw = 1'b0; cop = 1'b0;
      sub   = 1'b0; use_c = 1'b0; wr = 1'b1;
      a_sel = a_i;  b_sel = b_i;
      unique case (op)
         OP_ADD: arith = 1'b1;
         OP_ADC: begin arith = 1'b1; use_c = 1'b1; end
         OP_SUB: begin arith = 1'b1; sub = 1'b1; end
         OP_SBB: begin arith = 1'b1; sub = 1'b1; use_c = 1'b1; end
         OP_CMP: begin arith = 1'b1; sub = 1'b1; wr = 1'b0; end
         OP_NEG: begin arith = 1'b1; sub = 1'b1; a_sel = '0; b_sel = a_i; end
         OP_INC: begin arith = 1'b1; b_sel = ONE; end
         OP_DEC: begin arith = 1'b1; sub = 1'b1; b_sel = ONE; end
         OP_NOT, OP_AND, OP_OR, OP_XOR: bitw = 1'b1;
         OP_TST: begin bitw = 1'b1; wr = 1'b0; end
         default: begin cop = 1'b1; wr = 1'b0; end
      endcase
   end

   // subtraction as a + ~b + ~borrow
   assign cin_eff = use_c & c_i;
   assign add_y   = sub ? ~b_sel : b_sel;
   assign add_ci  = sub ? ~cin_eff : cin_eff;

   flex_alu_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .x_i  (a_sel),
      .y_i  (add_y),
      .ci_i (add_ci),
      .sum_o(sum),
      .co_o (cout)
   );

   assign ar_c = sub ? ~cout : cout;
   assign ar_v = sub ? ((a_sel[MSB] != b_sel[MSB]) && (sum[MSB] != a_sel[MSB]))
                     : ((a_sel[MSB] == b_sel[MSB]) && (sum[MSB] != a_sel[MSB]));

   flex_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .op_i (op),
      .a_i  (a_i),
      .b_i  (b_i),
      .res_o(lg_res)
   );

   assign res_o    = arith ? sum : (bitw ? lg_res : '0);
   assign res_we_o = wr;

   flex_alu_flags #(.WIDTH(WIDTH)) u_flags (
      .op_i   (op),
      .res_i  (res_o),
      .arith_i(arith),
      .bitw_i (bitw),
      .cop_i  (cop),
      .c_i    (c_i),
      .ar_c_i (ar_c),
      .ar_v_i (ar_v),
      .z_o    (z_o),
      .z_we_o (z_we_o),
      .c_o    (c_o),
      .c_we_o (c_we_o),
      .n_o    (n_o),
      .n_we_o (n_we_o),
      .v_o    (v_o),
      .v_we_o (v_we_o)
   );
endmodule

// File: rtl/flex_alu_check.sv
module flex_alu_check
   import flex_alu_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input logic [3:0]       op_i,
   input logic [WIDTH-1:0] a_i,
   input logic [WIDTH-1:0] b_i,
   input logic             c_i,
   input logic [WIDTH-1:0] res_o,
   input logic             res_we_o,
   input logic             z_o,
   input logic             z_we_o,
   input logic             c_o,
   input logic             c_we_o,
   input logic             n_o,
   input logic             n_we_o,
   input logic             v_o,
   input logic             v_we_o
);
   always_comb begin
      if (z_we_o)
         assert_zero_flag_R5: assert (z_o == (res_o == '0))
            else $error("zero flag disagrees with result");
      if (n_we_o)
         assert_neg_flag_R5: assert (n_o == res_o[WIDTH-1])
            else $error("negative flag disagrees with result");
      if (v_we_o)
         assert_arith_all_R6: assert (z_we_o && c_we_o && n_we_o)
            else $error("arithmetic op missing a flag enable");
      if (z_we_o && !v_we_o)
         assert_bitwise_zn_R7: assert (!c_we_o)
            else $error("bitwise op enabled carry");
      if (op_i == OP_CMP || op_i == OP_TST)
         assert_no_write_R8: assert (!res_we_o)
            else $error("compare/test wrote result");
      if (op_i == OP_INC)
         assert_inc_R9: assert (res_o == a_i + WIDTH'(1))
            else $error("increment result wrong");
      if (c_we_o && !z_we_o)
         assert_carry_only_R10: assert (!res_we_o && !n_we_o && !v_we_o && res_o == '0)
            else $error("carry op touched more than carry");
      assert_off_flags_zero_R11: assert ((z_we_o || !z_o) && (c_we_o || !c_o)
                                      && (n_we_o || !n_o) && (v_we_o || !v_o))
         else $error("disabled flag reads nonzero");
   end
endmodule

bind flex_alu flex_alu_check #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/flex_alu_test.sv
module flex_alu_test;
   import flex_alu_pkg::*;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [3:0]   op;
   logic [W-1:0] a, b;
   logic         cin;
   logic [W-1:0] res;
   logic         res_we, z, z_we, cf, c_we, n, n_we, v, v_we;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   flex_alu #(.WIDTH(W)) uut (
      .op_i(op), .a_i(a), .b_i(b), .c_i(cin),
      .res_o(res), .res_we_o(res_we),
      .z_o(z), .z_we_o(z_we), .c_o(cf), .c_we_o(c_we),
      .n_o(n), .n_we_o(n_we), .v_o(v), .v_we_o(v_we)
   );

   // independent reference from the requirement text
   task automatic model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic c, output logic [W-1:0] r, output logic [9:1] f);
      int u, s;
      bit ar, bw, cp, sb, rw, cc, vv;
      ar = 0; bw = 0; cp = 0; sb = 0; rw = 1; cc = 0; vv = 0; u = 0; s = 0;
      r = '0;
      case (o)
         4'd0:  begin ar = 1; u = int'(x) + int'(y);     s = int'($signed(x)) + int'($signed(y)); end
         4'd1:  begin ar = 1; u = int'(x) + int'(y) + int'(c); s = int'($signed(x)) + int'($signed(y)) + int'(c); end
         4'd2, 4'd4: begin ar = 1; sb = 1; u = int'(x) - int'(y); s = int'($signed(x)) - int'($signed(y)); rw = (o == 4'd2); end
         4'd3:  begin ar = 1; sb = 1; u = int'(x) - int'(y) - int'(c); s = int'($signed(x)) - int'($signed(y)) - int'(c); end
         4'd5:  begin ar = 1; sb = 1; u = 0 - int'(x); s = 0 - int'($signed(x)); end
         4'd6:  begin ar = 1; u = int'(x) + 1; s = int'($signed(x)) + 1; end
         4'd7:  begin ar = 1; sb = 1; u = int'(x) - 1; s = int'($signed(x)) - 1; end
         4'd8:  begin bw = 1; r = ~x; end
         4'd9:  begin bw = 1; r = x & y; end
         4'd10: begin bw = 1; r = x | y; end
         4'd11: begin bw = 1; r = x ^ y; end
         4'd12: begin bw = 1; r = x & y; rw = 0; end
         default: begin cp = 1; rw = 0; cc = (o == 4'd13) ? 1'b1 : (o == 4'd14) ? 1'b0 : ~c; end
      endcase
      if (ar) begin
         r  = u[W-1:0];
         cc = sb ? (u < 0) : (u > 65535);
         vv = (s > 32767) || (s < -32768);
      end
      // f: 1 rwe,2 z,3 zwe,4 c,5 cwe,6 n,7 nwe,8 v,9 vwe
      f[1] = rw;
      f[3] = ar | bw;         f[2] = f[3] & (r == '0);
      f[7] = ar | bw;         f[6] = f[7] & r[W-1];
      f[5] = ar | cp;         f[4] = f[5] & cc;
      f[9] = ar;              f[8] = ar & vv;
   endtask

   task automatic cmp(input string tag, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s op=%0d a=%h b=%h c=%b: got %h expected %h", tag, what, op, a, b, cin, got, exp);
      end
   endtask

   task automatic run(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y,
                      input logic c, input string tag);
      logic [W-1:0] er;
      logic [9:1]   ef;
      @(negedge clk);
      op = o; a = x; b = y; cin = c;
      @(posedge clk);
      #1;
      model(o, x, y, c, er, ef);
      cmp(tag, "res",   res,                 er);
      cmp(tag, "res_we",{15'd0, res_we},     {15'd0, ef[1]});
      cmp(tag, "z/zwe", {14'd0, z, z_we},    {14'd0, ef[2], ef[3]});
      cmp(tag, "c/cwe", {14'd0, cf, c_we},   {14'd0, ef[4], ef[5]});
      cmp(tag, "n/nwe", {14'd0, n, n_we},    {14'd0, ef[6], ef[7]});
      cmp(tag, "v/vwe", {14'd0, v, v_we},    {14'd0, ef[8], ef[9]});
   endtask

   task automatic t_idle;  // R5 R11 after reset: ADD of zeros
      run(4'd0, '0, '0, 1'b0, "R5");
      checks++;
      if (!(z === 1'b1 && res === '0)) begin fails++; $display("FAIL R5 idle z=%b res=%h expected 1 0000", z, res); end
   endtask

   task automatic t_add;   // R2 R4
      run(4'd0, 16'h7FFF, 16'h0001, 1'b0, "R4");
      run(4'd0, 16'hFFFF, 16'h0001, 1'b1, "R2");
      run(4'd0, 16'h8000, 16'h8000, 1'b0, "R4");
      run(4'd1, 16'h7FFF, 16'h0000, 1'b1, "R2");
      run(4'd1, 16'hFFFF, 16'hFFFF, 1'b1, "R2");
      run(4'd1, 16'h1234, 16'h4321, 1'b0, "R2");
   endtask

   task automatic t_sub;   // R3 R4
      run(4'd2, 16'h0000, 16'h0001, 1'b1, "R3");
      run(4'd2, 16'h8000, 16'h0001, 1'b0, "R4");
      run(4'd2, 16'h7FFF, 16'hFFFF, 1'b0, "R4");
      run(4'd3, 16'h0005, 16'h0005, 1'b1, "R3");
      run(4'd3, 16'h8000, 16'h0000, 1'b1, "R4");
      run(4'd3, 16'h0000, 16'h7FFF, 1'b1, "R4");
      run(4'd3, 16'h0005, 16'h0005, 1'b0, "R3");
   endtask

   task automatic t_nowrite; // R8
      run(4'd4, 16'h0003, 16'h0003, 1'b0, "R8");
      run(4'd4, 16'h8000, 16'h7FFF, 1'b1, "R8");
      run(4'd12, 16'hF0F0, 16'h0F0F, 1'b1, "R8");
      run(4'd12, 16'h8001, 16'hFFFF, 1'b0, "R8");
   endtask

   task automatic t_unary;  // R9 R6
      run(4'd5, 16'h0000, 16'h1111, 1'b1, "R9");
      run(4'd5, 16'h8000, 16'h0000, 1'b0, "R9");
      run(4'd5, 16'h0001, 16'hFFFF, 1'b0, "R9");
      run(4'd6, 16'h7FFF, 16'h5555, 1'b1, "R9");
      run(4'd6, 16'hFFFF, 16'h0000, 1'b1, "R9");
      run(4'd7, 16'h0000, 16'hAAAA, 1'b1, "R9");
      run(4'd7, 16'h8000, 16'h0000, 1'b0, "R6");
   endtask

   task automatic t_bitwise; // R7
      run(4'd8, 16'hFFFF, 16'h0000, 1'b1, "R7");
      run(4'd8, 16'h7FFF, 16'h0000, 1'b0, "R7");
      run(4'd9, 16'hFF00, 16'h0FF0, 1'b1, "R7");
      run(4'd10, 16'h0000, 16'h0000, 1'b1, "R7");
      run(4'd11, 16'hA5A5, 16'hA5A5, 1'b0, "R7");
      run(4'd11, 16'h8000, 16'h0001, 1'b1, "R7");
   endtask

   task automatic t_carry_ops; // R10 R11
      for (int c = 0; c < 2; c++) begin
         run(4'd13, 16'h1234, 16'h5678, c[0], "R10");
         run(4'd14, 16'hFFFF, 16'hFFFF, c[0], "R10");
         run(4'd15, 16'h8000, 16'h0000, c[0], "R11");
      end
   endtask

   task automatic t_mix;    // R1 every code with varied operands
      for (int k = 0; k < 400; k++) begin
         logic [W-1:0] x, y;
         x = W'($urandom);
         y = W'($urandom);
         if (k % 7 == 0) x = 16'h8000;
         if (k % 11 == 0) y = 16'h7FFF;
         run(4'(k % 16), x, y, k[4], "R1");
      end
   endtask

   initial begin
      op = 4'd0; a = '0; b = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_add();
      t_sub();
      t_nowrite();
      t_unary();
      t_bitwise();
      t_carry_ops();
      t_mix();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule